// File: doc/BRIEF.md
# Operand Addressing Mode Resolver

This block turns a 6-bit operand code into a 16-bit operand value for an instruction-executing core. It can also store a result back to the place that code names. One code space covers eight general registers, memory reached through a register, memory reached through a following instruction word (alone or plus a register), three stack forms, the stack pointer, the program counter, the overflow register, a following word used as a literal, and short literals held in the code itself. The block owns the general registers, SP, PC, O and the count of extra instruction words that are pending. It reaches memory through one request/response port.

The core issues one operand read per request on a valid/ready stream. It marks the destination operand with `rd_dst`. It then takes the value from a response stream that is held until accepted. When an operand code consumed an extra word, `rsp_wide` is set. For the destination operand, the block records the decoded mode and the memory address it resolved. A later writeback on the `wb_*` stream therefore goes to that same place and does not fetch the extra word again. The core pulses `commit` at the end of an instruction to add the pending extra-word count to PC.

Back-pressure rules:
- `rd_ready` and `wb_ready` are high only while the block is idle, and a read request takes precedence over a writeback in the same cycle.
- `rsp_valid` with `rsp_value` and `rsp_wide` stays asserted and unchanged until `rsp_ready`.
- A memory request holds its address, data and write flag until `mem_req_ready`.
- Read data comes back in order on `mem_rsp_valid`, which is never back-pressured.

Top module: `opnd_resolver`

## Requirements
- R1: Codes 0x00-0x07 read or write general registers 0-7 directly; no memory access, `rsp_wide`=0.
- R2: Codes 0x08-0x0F read or write memory at the address held in general register (code-0x08).
- R3: Codes 0x10-0x17 fetch the word at PC+pending, increment pending, and access memory at that word plus general register (code-0x10), with `rsp_wide`=1.
- R4: Code 0x18 read returns memory at SP, then SP increments by one; a writeback to 0x18 stores nothing and leaves SP unchanged.
- R5: Code 0x19 accesses memory at SP with SP unchanged; a 0x1A read returns 0 with SP unchanged, and a 0x1A writeback decrements SP and stores at the new SP.
- R6: Codes 0x1B, 0x1C and 0x1D access SP, PC and O; a 0x1C read returns PC+pending.
- R7: Code 0x1E fetches a next word and accesses memory at it; code 0x1F fetches a next word and returns it as the value; a writeback to 0x1F is discarded; both set `rsp_wide`=1.
- R8: Codes 0x20-0x3F read as the value code-0x20 (0 to 31); writebacks to them change nothing.
- R9: A writeback to PC loads PC and clears pending; `commit` adds pending to PC and clears it.
- R10: Extra words are fetched in request order, and a writeback uses the mode and address captured at the last destination read, even if the next word in memory has since changed.
- R11: `rd_ready`/`wb_ready` are low while busy; response and memory request hold stable until accepted.
- R12: After reset all registers, SP, PC, O and pending are 0, `rd_ready` is 1, and no response or memory request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Operand read request valid |
| rd_ready | output | 1 | Block accepts a read request |
| rd_code | input | 6 | Operand code |
| rd_dst | input | 1 | Request is the destination operand; capture for writeback |
| rsp_valid | output | 1 | Operand value valid |
| rsp_ready | input | 1 | Core accepts the value |
| rsp_value | output | 16 | Resolved operand value |
| rsp_wide | output | 1 | Operand consumed an extra instruction word |
| wb_valid | input | 1 | Writeback request valid |
| wb_ready | output | 1 | Block accepts the writeback |
| wb_data | input | 16 | Data to store at the captured destination |
| commit | input | 1 | End of instruction: fold pending words into PC |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 16 | Memory address |
| mem_req_wdata | output | 16 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 16 | Read data |

## Verification
The bench stalls both the memory port and the response stream on fixed cycle patterns. A block that dropped or changed a held request would then return wrong values or skip a word. It changes the extra word in memory between a destination read and its writeback. A block that fetched the word again would then store to a different address, which a later read through an absolute address exposes. It checks PC reads before and after `commit` and after a PC writeback. A block that let a PC write keep its pending count would read back too far. It also stores to a pop code and to literals, then reads memory and SP back. A block that treated those codes as real targets would show a stored word or a moved SP.

// File: rtl/opr_pkg.sv
package opr_pkg;
  localparam int unsigned OPR_NREG  = 8;
  localparam int unsigned OPR_CODEW = 6;
  localparam int unsigned OPR_LITW  = 5;

  typedef enum logic [3:0] {
    CL_REG, CL_IND, CL_IDX, CL_POP, CL_PEEK, CL_PUSH,
    CL_SP, CL_PC, CL_OVF, CL_ABS, CL_NWL, CL_LIT
  } opr_class_e;

  typedef struct packed {
    opr_class_e            cls;
    logic [2:0]            ridx;
    logic [OPR_LITW-1:0]   lit;
    logic                  nw;
  } opr_dec_t;

  typedef enum logic [2:0] {
    S_IDLE, S_NW_REQ, S_NW_WAIT, S_OP_REQ, S_OP_WAIT, S_RESP, S_WR_REQ
  } opr_state_e;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [OPR_CODEW-1:0] code,
  output opr_dec_t             dec
);
  always_comb begin
    dec.ridx = code[2:0];
    dec.lit  = code[OPR_LITW-1:0];
    dec.nw   = 1'b0;
    dec.cls  = CL_LIT;
    if (code[5]) begin
      dec.cls = CL_LIT;
    end else begin
      unique case (code[4:3])
        2'b00: dec.cls = CL_REG;
        2'b01: dec.cls = CL_IND;
        2'b10: begin dec.cls = CL_IDX; dec.nw = 1'b1; end
        default: begin
          unique case (code[2:0])
            3'd0: dec.cls = CL_POP;
            3'd1: dec.cls = CL_PEEK;
            3'd2: dec.cls = CL_PUSH;
            3'd3: dec.cls = CL_SP;
            3'd4: dec.cls = CL_PC;
            3'd5: dec.cls = CL_OVF;
            3'd6: begin dec.cls = CL_ABS; dec.nw = 1'b1; end
            default: begin dec.cls = CL_NWL; dec.nw = 1'b1; end
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/opr_regs.sv
module opr_regs
  import opr_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned OFSW = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DW-1:0]                 wdata,
  input  logic                          gpr_we,
  input  logic [2:0]                    gpr_idx,
  input  logic                          sp_we,
  input  logic                          sp_inc,
  input  logic                          sp_dec,
  input  logic                          pc_we,
  input  logic                          o_we,
  input  logic                          ofs_inc,
  input  logic                          commit,
  output logic [OPR_NREG-1:0][DW-1:0]   gpr_q,
  output logic [DW-1:0]                 sp_q,
  output logic [DW-1:0]                 pc_q,
  output logic [DW-1:0]                 o_q,
  output logic [OFSW-1:0]               ofs_q
);
  localparam logic [DW-1:0] ONE = DW'(1);

  for (genvar g = 0; g < OPR_NREG; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rst_n)                                   gpr_q[g] <= '0;
      else if (gpr_we && gpr_idx == 3'(g))          gpr_q[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       sp_q <= '0;
    else if (sp_we)   sp_q <= wdata;
    else if (sp_inc)  sp_q <= sp_q + ONE;
    else if (sp_dec)  sp_q <= sp_q - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      o_q <= '0;
    else if (o_we)   o_q <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      ofs_q <= '0;
    end else if (pc_we) begin
      pc_q  <= wdata;
      ofs_q <= '0;
    end else if (commit) begin
      pc_q  <= pc_q + {{(DW-OFSW){1'b0}}, ofs_q};
      ofs_q <= {{(OFSW-1){1'b0}}, ofs_inc};
    end else if (ofs_inc) begin
      ofs_q <= ofs_q + 1'b1;
    end
  end

  assert_pc_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we |=> (ofs_q == '0));
  assert_push_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_dec && !sp_we) |=> (sp_q == $past(sp_q) - ONE));
  assert_pop_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sp_inc && !sp_we) |=> (sp_q == $past(sp_q) + ONE));
  assert_ofs_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ofs_inc && !commit) |-> (ofs_q != '1));
endmodule

// File: rtl/opr_seq.sv
module opr_seq
  import opr_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned OFSW = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_valid,
  input  logic                          rd_dst,
  input  opr_dec_t                      dec_in,
  output logic                          rd_ready,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic [DW-1:0]                 rsp_value,
  output logic                          rsp_wide,
  input  logic                          wb_valid,
  input  logic [DW-1:0]                 wb_data,
  output logic                          wb_ready,
  output logic                          mem_req_valid,
  input  logic                          mem_req_ready,
  output logic                          mem_req_we,
  output logic [DW-1:0]                 mem_req_addr,
  output logic [DW-1:0]                 mem_req_wdata,
  input  logic                          mem_rsp_valid,
  input  logic [DW-1:0]                 mem_rsp_data,
  input  logic [OPR_NREG-1:0][DW-1:0]   gpr_q,
  input  logic [DW-1:0]                 sp_q,
  input  logic [DW-1:0]                 pc_q,
  input  logic [DW-1:0]                 o_q,
  input  logic [OFSW-1:0]               ofs_q,
  output logic [DW-1:0]                 wdata,
  output logic                          gpr_we,
  output logic [2:0]                    gpr_idx,
  output logic                          sp_we,
  output logic                          sp_inc,
  output logic                          sp_dec,
  output logic                          pc_we,
  output logic                          o_we,
  output logic                          ofs_inc
);
  localparam logic [DW-1:0] ONE = DW'(1);

  opr_state_e st;
  opr_dec_t   cur_q, dst_q;
  logic       dst_flag;
  logic [DW-1:0] addr_q, wdat_q, val_q, dst_addr, imm_val, nw_ptr;
  logic       wide_q, rd_take, wb_take, dst_mem;

  assign nw_ptr   = pc_q + {{(DW-OFSW){1'b0}}, ofs_q};
  assign rd_take  = (st == S_IDLE) && rd_valid;
  assign wb_take  = (st == S_IDLE) && !rd_valid && wb_valid;
  assign rd_ready = (st == S_IDLE);
  assign wb_ready = (st == S_IDLE) && !rd_valid;
  assign dst_mem  = (dst_q.cls == CL_IND) || (dst_q.cls == CL_IDX) ||
                    (dst_q.cls == CL_ABS) || (dst_q.cls == CL_PEEK);

  always_comb begin
    unique case (dec_in.cls)
      CL_REG:  imm_val = gpr_q[dec_in.ridx];
      CL_SP:   imm_val = sp_q;
      CL_PC:   imm_val = nw_ptr;
      CL_OVF:  imm_val = o_q;
      CL_LIT:  imm_val = {{(DW-OPR_LITW){1'b0}}, dec_in.lit};
      default: imm_val = '0;
    endcase
  end

  always_comb begin
    gpr_we = 1'b0; sp_we = 1'b0; sp_inc = 1'b0; sp_dec = 1'b0;
    pc_we  = 1'b0; o_we  = 1'b0; ofs_inc = 1'b0;
    gpr_idx = dst_q.ridx;
    wdata   = wb_data;
    if (rd_take && dec_in.cls == CL_POP) sp_inc = 1'b1;
    if (st == S_NW_REQ && mem_req_ready) ofs_inc = 1'b1;
    if (wb_take) begin
      unique case (dst_q.cls)
        CL_REG:  gpr_we = 1'b1;
        CL_SP:   sp_we  = 1'b1;
        CL_PC:   pc_we  = 1'b1;
        CL_OVF:  o_we   = 1'b1;
        CL_PUSH: sp_dec = 1'b1;
        default: ;
      endcase
    end
  end

  assign mem_req_valid = (st == S_NW_REQ) || (st == S_OP_REQ) || (st == S_WR_REQ);
  assign mem_req_we    = (st == S_WR_REQ);
  assign mem_req_addr  = (st == S_NW_REQ) ? nw_ptr : addr_q;
  assign mem_req_wdata = wdat_q;
  assign rsp_valid     = (st == S_RESP);
  assign rsp_value     = val_q;
  assign rsp_wide      = wide_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_q    <= '{cls: CL_LIT, ridx: 3'd0, lit: '0, nw: 1'b0};
      dst_q    <= '{cls: CL_LIT, ridx: 3'd0, lit: '0, nw: 1'b0};
      dst_flag <= 1'b0;
      addr_q   <= '0;
      wdat_q   <= '0;
      val_q    <= '0;
      dst_addr <= '0;
      wide_q   <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (rd_valid) begin
            cur_q    <= dec_in;
            dst_flag <= rd_dst;
            wide_q   <= dec_in.nw;
            if (rd_dst) dst_q <= dec_in;
            unique case (dec_in.cls)
              CL_IDX, CL_ABS, CL_NWL: st <= S_NW_REQ;
              CL_IND: begin
                addr_q <= gpr_q[dec_in.ridx];
                if (rd_dst) dst_addr <= gpr_q[dec_in.ridx];
                st <= S_OP_REQ;
              end
              CL_POP, CL_PEEK: begin
                addr_q <= sp_q;
                if (rd_dst) dst_addr <= sp_q;
                st <= S_OP_REQ;
              end
              default: begin
                val_q <= imm_val;
                st    <= S_RESP;
              end
            endcase
          end else if (wb_valid) begin
            wdat_q <= wb_data;
            if (dst_mem) begin
              addr_q <= dst_addr;
              st     <= S_WR_REQ;
            end else if (dst_q.cls == CL_PUSH) begin
              addr_q <= sp_q - ONE;
              st     <= S_WR_REQ;
            end
          end
        end
        S_NW_REQ: if (mem_req_ready) st <= S_NW_WAIT;
        S_NW_WAIT: begin
          if (mem_rsp_valid) begin
            unique case (cur_q.cls)
              CL_NWL: begin
                val_q <= mem_rsp_data;
                st    <= S_RESP;
              end
              CL_ABS: begin
                addr_q <= mem_rsp_data;
                if (dst_flag) dst_addr <= mem_rsp_data;
                st <= S_OP_REQ;
              end
              default: begin
                addr_q <= mem_rsp_data + gpr_q[cur_q.ridx];
                if (dst_flag) dst_addr <= mem_rsp_data + gpr_q[cur_q.ridx];
                st <= S_OP_REQ;
              end
            endcase
          end
        end
        S_OP_REQ: if (mem_req_ready) st <= S_OP_WAIT;
        S_OP_WAIT: begin
          if (mem_rsp_valid) begin
            val_q <= mem_rsp_data;
            st    <= S_RESP;
          end
        end
        S_RESP:   if (rsp_ready) st <= S_IDLE;
        S_WR_REQ: if (mem_req_ready) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_value) && $stable(rsp_wide)));
  assert_memreq_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  assert_busy_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req_valid) |-> (!rd_ready && !wb_ready));
  assert_sp_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sp_we, sp_inc, sp_dec}));
  assert_lit_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_take && dst_q.cls == CL_LIT) |=> (rd_ready && !mem_req_valid));
endmodule

// File: rtl/opnd_resolver.sv
module opnd_resolver
  import opr_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned OFSW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [5:0]    rd_code,
  input  logic          rd_dst,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_value,
  output logic          rsp_wide,
  input  logic          wb_valid,
  output logic          wb_ready,
  input  logic [DW-1:0] wb_data,
  input  logic          commit,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [DW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  opr_dec_t                     dec;
  logic [OPR_NREG-1:0][DW-1:0]  gpr_q;
  logic [DW-1:0]                sp_q, pc_q, o_q, wdata;
  logic [OFSW-1:0]              ofs_q;
  logic [2:0]                   gpr_idx;
  logic gpr_we, sp_we, sp_inc, sp_dec, pc_we, o_we, ofs_inc;

  opr_decode u_dec (.code(rd_code), .dec(dec));

  opr_seq #(.DW(DW), .OFSW(OFSW)) u_seq (
    .clk, .rst_n, .rd_valid, .rd_dst, .dec_in(dec), .rd_ready,
    .rsp_valid, .rsp_ready, .rsp_value, .rsp_wide,
    .wb_valid, .wb_data, .wb_ready,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data,
    .gpr_q, .sp_q, .pc_q, .o_q, .ofs_q,
    .wdata, .gpr_we, .gpr_idx, .sp_we, .sp_inc, .sp_dec, .pc_we, .o_we, .ofs_inc
  );

  opr_regs #(.DW(DW), .OFSW(OFSW)) u_regs (
    .clk, .rst_n, .wdata, .gpr_we, .gpr_idx, .sp_we, .sp_inc, .sp_dec,
    .pc_we, .o_we, .ofs_inc, .commit,
    .gpr_q, .sp_q, .pc_q, .o_q, .ofs_q
  );

  assert_reset_idle_R12: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_ready && !rsp_valid && !mem_req_valid));
endmodule

// File: tb/sim_opnd_resolver.sv
module sim_opnd_resolver;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        rd_valid = 1'b0, rd_dst = 1'b0, wb_valid = 1'b0, commit = 1'b0;
  logic [5:0]  rd_code = '0;
  logic [15:0] wb_data = '0;
  logic        rsp_ready = 1'b1, mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [15:0] mem_rsp_data = '0;
  logic        rd_ready, rsp_valid, rsp_wide, wb_ready, mem_req_valid, mem_req_we;
  logic [15:0] rsp_value, mem_req_addr, mem_req_wdata;

  opnd_resolver u0 (
    .clk, .rst_n, .rd_valid, .rd_ready, .rd_code, .rd_dst,
    .rsp_valid, .rsp_ready, .rsp_value, .rsp_wide,
    .wb_valid, .wb_ready, .wb_data, .commit,
    .mem_req_valid, .mem_req_ready, .mem_req_we, .mem_req_addr, .mem_req_wdata,
    .mem_rsp_valid, .mem_rsp_data
  );

  int vecs = 0, bad = 0, ncyc = 0;
  logic [16:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] bmem [256];

  task automatic chk(input bit ok, input string tag, input logic [16:0] act, input logic [16:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: ready pattern at negedge, 1-cycle read latency
  always @(negedge clk) begin
    ncyc++;
    mem_req_ready = (ncyc % 3) != 1;
    rsp_ready     = (ncyc % 4) != 3;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected response", {rsp_wide, rsp_value}, 17'h0);
      else begin
        logic [16:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({rsp_wide, rsp_value} == e, t, {rsp_wide, rsp_value}, e);
      end
    end
  end

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_we) bmem[mem_req_addr[7:0]] = mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= bmem[mem_req_addr[7:0]];
      end
    end
  end

  task automatic do_read(input logic [5:0] code, input bit dst, input logic [15:0] ev,
                         input bit ew, input string tag);
    @(negedge clk);
    rd_valid = 1'b1; rd_code = code; rd_dst = dst;
    while (!rd_ready) @(negedge clk);
    exp_q.push_back({ew, ev});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  task automatic do_wb(input logic [15:0] d);
    @(negedge clk);
    wb_valid = 1'b1; wb_data = d;
    while (!wb_ready) @(negedge clk);
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!rd_ready || exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic do_commit();
    wait_idle();
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bmem[i] = {i[7:0], i[7:0]};
    bmem[0] = 16'h0030; bmem[1] = 16'h0005; bmem[2] = 16'h0072; bmem[3] = 16'h0033;
    bmem[8'h20] = 16'h5A5A; bmem[8'h21] = 16'h0004; bmem[8'h42] = 16'hBEEF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rd_ready && !rsp_valid && !mem_req_valid, "R12 idle after reset",
        {14'h0, rd_ready, rsp_valid, mem_req_valid}, 17'h4);
    do_read(6'h00, 0, 16'h0000, 0, "R12 reg A reset");
    do_read(6'h1B, 0, 16'h0000, 0, "R12 SP reset");
    do_read(6'h1C, 0, 16'h0000, 0, "R12 PC reset");
    // R1 registers
    do_read(6'h00, 1, 16'h0000, 0, "R1 dst A");   wait_idle(); do_wb(16'h0042);
    do_read(6'h00, 0, 16'h0042, 0, "R1 A written");
    do_read(6'h07, 1, 16'h0000, 0, "R1 dst J");   wait_idle(); do_wb(16'h0010);
    do_read(6'h07, 0, 16'h0010, 0, "R1 J written");
    // R8 literals
    do_read(6'h25, 0, 16'd5,  0, "R8 lit 5");
    do_read(6'h3F, 0, 16'd31, 0, "R8 lit 31");
    do_read(6'h20, 0, 16'd0,  0, "R8 lit 0");
    do_read(6'h25, 1, 16'd5,  0, "R8 dst lit"); wait_idle(); do_wb(16'h1234);
    do_read(6'h25, 0, 16'd5,  0, "R8 lit after write");
    do_read(6'h00, 0, 16'h0042, 0, "R8 A untouched");
    // R2 indirect
    do_read(6'h08, 0, 16'hBEEF, 0, "R2 [A]");
    do_read(6'h0F, 1, 16'h1010, 0, "R2 dst [J]"); wait_idle(); do_wb(16'h2222);
    do_read(6'h0F, 0, 16'h2222, 0, "R2 [J] written");
    // R3/R7/R10 next words
    do_read(6'h10, 1, 16'h7272, 1, "R3 [nw+A]");
    do_read(6'h1F, 0, 16'h0005, 1, "R7 nw literal second word R10");
    do_read(6'h1C, 0, 16'h0002, 0, "R6 PC plus pending");
    wait_idle();
    bmem[0] = 16'h0050;
    do_wb(16'h9999);
    wait_idle();
    chk(bmem[8'h72] == 16'h9999, "R10 captured dst addr", {1'b0, bmem[8'h72]}, 17'h09999);
    chk(bmem[8'h92] == 16'h9292, "R10 no refetch", {1'b0, bmem[8'h92]}, 17'h09292);
    do_commit();
    do_read(6'h1E, 0, 16'h9999, 1, "R7 [nw]");
    do_read(6'h1C, 0, 16'h0003, 0, "R6 PC after commit R9");
    do_commit();
    // R5/R4 stack
    do_read(6'h1A, 1, 16'h0000, 0, "R5 push read zero"); wait_idle(); do_wb(16'h0AAA);
    wait_idle();
    chk(bmem[8'hFF] == 16'h0AAA, "R5 push store", {1'b0, bmem[8'hFF]}, 17'h00AAA);
    do_read(6'h1B, 0, 16'hFFFF, 0, "R5 SP after push");
    do_read(6'h19, 0, 16'h0AAA, 0, "R5 peek");
    do_read(6'h1B, 0, 16'hFFFF, 0, "R5 SP after peek");
    do_read(6'h18, 0, 16'h0AAA, 0, "R4 pop");
    do_read(6'h1B, 0, 16'h0000, 0, "R4 SP after pop");
    do_read(6'h18, 1, 16'h0050, 0, "R4 dst pop"); wait_idle(); do_wb(16'h7777);
    wait_idle();
    chk(bmem[0] == 16'h0050, "R4 pop write no store", {1'b0, bmem[0]}, 17'h00050);
    do_read(6'h1B, 1, 16'h0001, 0, "R4 SP after pop write"); wait_idle(); do_wb(16'h0000);
    do_read(6'h19, 0, 16'h0050, 0, "R6 SP written, peek");
    // R6 O
    do_read(6'h1D, 1, 16'h0000, 0, "R6 O reset"); wait_idle(); do_wb(16'h00C3);
    do_read(6'h1D, 0, 16'h00C3, 0, "R6 O written");
    // R9 PC write
    do_read(6'h1C, 1, 16'h0003, 0, "R9 dst PC");
    do_read(6'h1F, 0, 16'h0033, 1, "R7 nw at PC 3");
    wait_idle(); do_wb(16'h0020);
    do_read(6'h1C, 0, 16'h0020, 0, "R9 PC write clears pending");
    do_commit();
    do_read(6'h1C, 0, 16'h0020, 0, "R9 commit with none pending");
    do_read(6'h1F, 0, 16'h5A5A, 1, "R7 nw literal");
    do_commit();
    do_read(6'h1C, 0, 16'h0021, 0, "R9 commit folds pending");
    do_read(6'h17, 0, 16'h1414, 1, "R3 [nw+J]");
    wait_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule